// File: doc/BRIEF.md
# Filtered Fault Latch Supervisor

This block sits between the raw fault comparators of a six-channel half-bridge driver and its output stage. Every raw condition (per-output overcurrent and open-load, temperature warning, thermal shutdown, supply undervoltage on the logic-side, A-bank and B-bank rails, supply overvoltage) goes through its own persistence filter. A condition that survives the filter sets a sticky status flag. The flags then decide which outputs the driver must hold off.

Fault classes differ in filter length and in shutdown scope. Overcurrent removes only its own output. Thermal shutdown and the undervoltage faults remove all outputs. Overvoltage removes all outputs unless a mask input is set. Open-load and temperature warning only report. Only a host clear strobe removes a flag, and with it the disable it causes. Reset and standby wipe all flags and all filter progress.

Top module: `fault_latch_supervisor`

## Requirements
- R1: With rst_ni low, or on any clock edge where standby_i is high, every flag and every filter counter goes to zero. After such an edge out_dis_o is zero, unless ov_mask_i is irrelevant because no flag is set.
- R2: A short-filtered raw input sets its flag on the SHORT_CYC-th consecutive clock edge at which it is sampled high. A run of SHORT_CYC-1 edges sets nothing.
- R3: When a raw input is sampled low before its filter completes, the count restarts from zero. A following run needs a full interval again.
- R4: A filtered oc_raw_i[i] sets oc_flag_o[i] and out_dis_o[i], and no other out_dis_o bit. Both stay set until oc_clr_i[i] is pulsed.
- R5: ol_raw_i[i] is counted only on edges where out_on_i[i] is also high. It sets ol_flag_o[i] after LONG_CYC such edges, and ol_flag_o never affects out_dis_o.
- R6: Temperature warning latches into glob_flag_o[0] after the short filter and never affects out_dis_o.
- R7: Thermal shutdown latches into glob_flag_o[1] and drives all out_dis_o bits high. A clear strobe glob_clr_i[1] is ignored while tsd_raw_i is high.
- R8: VS, VSA and VSB undervoltage latch into glob_flag_o[2], glob_flag_o[4] and glob_flag_o[5]. Each of these bits drives all out_dis_o bits high.
- R9: VS overvoltage latches into glob_flag_o[3]. That bit drives all out_dis_o bits high only while ov_mask_i is low.
- R10: A clear strobe (except the ignored case of R7) zeroes its flag at the next edge even if the raw input stays high. The flag sets again only after a full new filter interval counted from the edge after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby: clears all flags and filters |
| oc_raw_i | input | N_OUT | Raw overcurrent per output |
| ol_raw_i | input | N_OUT | Raw open-load per output |
| out_on_i | input | N_OUT | Output currently commanded on |
| tw_raw_i | input | 1 | Raw temperature warning |
| tsd_raw_i | input | 1 | Raw thermal shutdown (hysteresis applied outside) |
| vs_uv_raw_i | input | 1 | Raw VS undervoltage |
| vs_ov_raw_i | input | 1 | Raw VS overvoltage |
| vsa_uv_raw_i | input | 1 | Raw A-bank rail undervoltage |
| vsb_uv_raw_i | input | 1 | Raw B-bank rail undervoltage |
| ov_mask_i | input | 1 | Suppress overvoltage shutdown |
| oc_clr_i | input | N_OUT | Overcurrent flag clear strobes |
| ol_clr_i | input | N_OUT | Open-load flag clear strobes |
| glob_clr_i | input | 6 | Global flag clear strobes, same bit order as glob_flag_o |
| oc_flag_o | output | N_OUT | Latched overcurrent flags |
| ol_flag_o | output | N_OUT | Latched open-load flags |
| glob_flag_o | output | 6 | Latched global flags |
| out_dis_o | output | N_OUT | Per-output forced-off vector |

## Verification
The bench aims at the filter boundary: a run one edge short of the interval, and a dropout in the middle of a run. A design off by one, or one that kept counting across a dropout, would set flags early. It pulses clears while the raw fault persists. A design that failed to restart its filter would set the flag again at once, and one that ignored the thermal-hot rule would re-enable outputs while the die is still hot. It also toggles out_on_i under an open-load fault, toggles the overvoltage mask and enters standby. A leaky design would then report faults on idle outputs, hold outputs off while masked, or keep stale flags.

// File: rtl/fsup_pkg.sv
`timescale 1ns/1ps
package fsup_pkg;
  localparam int GF_TW    = 0;
  localparam int GF_TSD   = 1;
  localparam int GF_VSUV  = 2;
  localparam int GF_VSOV  = 3;
  localparam int GF_VSAUV = 4;
  localparam int GF_VSBUV = 5;
  localparam int GF_N     = 6;
endpackage

// File: rtl/fsup_filter.sv
`timescale 1ns/1ps
module fsup_filter #(
  parameter int LIMIT = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic restart_i,
  output logic fire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !raw_i) cnt_q <= '0;
    else if (cnt_q != LIM_C)      cnt_q <= cnt_q + 1'b1;
  end

  // fires once per run; saturation at LIMIT blocks refire
  assign fire_o = raw_i & ~restart_i & (cnt_q == LIM_M1);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM_C);
  assert_run_needed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LIMIT > 1 && fire_o) |-> $past(raw_i));
endmodule

// File: rtl/fsup_chan.sv
`timescale 1ns/1ps
module fsup_chan #(
  parameter int LIMIT = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic clr_i,
  input  logic stby_i,
  output logic flag_o
);
  logic restart, fire;

  assign restart = clr_i | stby_i;

  fsup_filter #(.LIMIT(LIMIT)) filt_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_i    (raw_i),
    .restart_i(restart),
    .fire_o   (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (restart) flag_o <= 1'b0;
    else if (fire)    flag_o <= 1'b1;
  end

  assert_clr_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);
  assert_flag_needs_raw_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(raw_i));
endmodule

// File: rtl/fault_latch_supervisor.sv
`timescale 1ns/1ps
module fault_latch_supervisor #(
  parameter int N_OUT     = 6,
  parameter int SHORT_CYC = 1600,
  parameter int LONG_CYC  = 100000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic [N_OUT-1:0] oc_raw_i,
  input  logic [N_OUT-1:0] ol_raw_i,
  input  logic [N_OUT-1:0] out_on_i,
  input  logic             tw_raw_i,
  input  logic             tsd_raw_i,
  input  logic             vs_uv_raw_i,
  input  logic             vs_ov_raw_i,
  input  logic             vsa_uv_raw_i,
  input  logic             vsb_uv_raw_i,
  input  logic             ov_mask_i,
  input  logic [N_OUT-1:0] oc_clr_i,
  input  logic [N_OUT-1:0] ol_clr_i,
  input  logic [5:0]       glob_clr_i,
  output logic [N_OUT-1:0] oc_flag_o,
  output logic [N_OUT-1:0] ol_flag_o,
  output logic [5:0]       glob_flag_o,
  output logic [N_OUT-1:0] out_dis_o
);
  import fsup_pkg::*;

  logic [GF_N-1:0] glob_raw, glob_clr;
  logic            global_off;

  always_comb begin
    glob_raw           = '0;
    glob_raw[GF_TW]    = tw_raw_i;
    glob_raw[GF_TSD]   = tsd_raw_i;
    glob_raw[GF_VSUV]  = vs_uv_raw_i;
    glob_raw[GF_VSOV]  = vs_ov_raw_i;
    glob_raw[GF_VSAUV] = vsa_uv_raw_i;
    glob_raw[GF_VSBUV] = vsb_uv_raw_i;
    glob_clr           = glob_clr_i;
    // thermal bit cannot be cleared while still hot
    glob_clr[GF_TSD]   = glob_clr_i[GF_TSD] & ~tsd_raw_i;
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    fsup_chan #(.LIMIT(SHORT_CYC)) oc_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(oc_raw_i[i]),
      .clr_i(oc_clr_i[i]), .stby_i(standby_i), .flag_o(oc_flag_o[i]));
    fsup_chan #(.LIMIT(LONG_CYC)) ol_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(ol_raw_i[i] & out_on_i[i]),
      .clr_i(ol_clr_i[i]), .stby_i(standby_i), .flag_o(ol_flag_o[i]));
  end

  for (genvar g = 0; g < GF_N; g++) begin : g_glob
    fsup_chan #(.LIMIT(SHORT_CYC)) gl_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(glob_raw[g]),
      .clr_i(glob_clr[g]), .stby_i(standby_i), .flag_o(glob_flag_o[g]));
  end

  assign global_off = glob_flag_o[GF_TSD] | glob_flag_o[GF_VSUV] |
                      glob_flag_o[GF_VSAUV] | glob_flag_o[GF_VSBUV] |
                      (glob_flag_o[GF_VSOV] & ~ov_mask_i);
  assign out_dis_o  = oc_flag_o | {N_OUT{global_off}};

  assert_oc_isolates_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_flag_o & ~out_dis_o) == '0);
  assert_tsd_all_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_flag_o[GF_TSD] |-> (&out_dis_o));
  assert_tsd_hot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glob_flag_o[GF_TSD] && tsd_raw_i && !standby_i) |=> glob_flag_o[GF_TSD]);
  assert_standby_wipe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (oc_flag_o == '0 && ol_flag_o == '0 && glob_flag_o == '0));
  assert_ol_needs_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ol_flag_o & ~$past(ol_flag_o) & ~$past(out_on_i)) == '0);
endmodule

// File: tb/fault_latch_supervisor_tb_top.sv
`timescale 1ns/1ps
module fault_latch_supervisor_tb_top;
  localparam int SHORT = 8;
  localparam int LONG  = 24;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       standby_i = 1'b0;
  logic [5:0] oc_raw = '0, ol_raw = '0, out_on = '0, glob_raw = '0;
  logic       ov_mask = 1'b0;
  logic [5:0] oc_clr = '0, ol_clr = '0, glob_clr = '0;
  logic [5:0] oc_flag, ol_flag, glob_flag, out_dis;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  int m_cnt [18];
  bit m_flag[18];

  always #10 clk_i = ~clk_i;

  fault_latch_supervisor #(.N_OUT(6), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i),
    .oc_raw_i(oc_raw), .ol_raw_i(ol_raw), .out_on_i(out_on),
    .tw_raw_i(glob_raw[0]), .tsd_raw_i(glob_raw[1]), .vs_uv_raw_i(glob_raw[2]),
    .vs_ov_raw_i(glob_raw[3]), .vsa_uv_raw_i(glob_raw[4]), .vsb_uv_raw_i(glob_raw[5]),
    .ov_mask_i(ov_mask), .oc_clr_i(oc_clr), .ol_clr_i(ol_clr), .glob_clr_i(glob_clr),
    .oc_flag_o(oc_flag), .ol_flag_o(ol_flag), .glob_flag_o(glob_flag), .out_dis_o(out_dis));

  // reference model built from R1..R10
  always @(posedge clk_i) begin
    for (int c = 0; c < 18; c++) begin
      bit r, cl;
      int lim;
      if (c < 6) begin
        r = oc_raw[c]; cl = oc_clr[c]; lim = SHORT;
      end else if (c < 12) begin
        r = ol_raw[c-6] & out_on[c-6]; cl = ol_clr[c-6]; lim = LONG;
      end else begin
        r = glob_raw[c-12]; cl = glob_clr[c-12]; lim = SHORT;
        if (c == 13) cl = cl & ~glob_raw[1];
      end
      if (!rst_ni || standby_i || cl) begin
        m_cnt[c] = 0; m_flag[c] = 1'b0;
      end else if (!r) begin
        m_cnt[c] = 0;
      end else begin
        if (m_cnt[c] == lim - 1) m_flag[c] = 1'b1;
        if (m_cnt[c] < lim) m_cnt[c] = m_cnt[c] + 1;
      end
    end
  end

  function automatic logic [5:0] mvec(int base);
    logic [5:0] v;
    for (int k = 0; k < 6; k++) v[k] = m_flag[base+k];
    return v;
  endfunction

  function automatic logic [5:0] exp_dis();
    logic [5:0] g;
    logic off;
    g = mvec(12);
    off = g[1] | g[2] | g[4] | g[5] | (g[3] & ~ov_mask);
    return mvec(0) | {6{off}};
  endfunction

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i); #2;
      chk("R4 oc_flag", oc_flag, mvec(0));
      chk("R5 ol_flag", ol_flag, mvec(6));
      chk("R6 R7 R8 R9 glob_flag", glob_flag, mvec(12));
      chk("R4 R7 R8 R9 out_dis", out_dis, exp_dis());
    end
  endtask

  task automatic pulse_clr(logic [5:0] oc, logic [5:0] ol, logic [5:0] gl);
    oc_clr = oc; ol_clr = ol; glob_clr = gl;
    step(1);
    oc_clr = '0; ol_clr = '0; glob_clr = '0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    step(1);
    chk("R1 reset flags", oc_flag | ol_flag | glob_flag, 6'b0);
    chk("R1 reset dis", out_dis, 6'b0);

    oc_raw[2] = 1'b1;
    step(SHORT - 1);
    chk("R2 short run", oc_flag, 6'b0);
    step(1);
    chk("R2 R4 flag set", oc_flag, 6'b000100);
    chk("R4 only own output", out_dis, 6'b000100);

    oc_raw[4] = 1'b1; step(5);
    oc_raw[4] = 1'b0; step(1);
    oc_raw[4] = 1'b1; step(SHORT - 1);
    chk("R3 dropout restart", oc_flag[4] ? 6'b1 : 6'b0, 6'b0);
    step(1);
    chk("R3 full rerun", oc_flag, 6'b010100);

    pulse_clr(6'b000100, '0, '0);
    chk("R10 clear while raw", oc_flag[2] ? 6'b1 : 6'b0, 6'b0);
    chk("R10 output back on", out_dis, 6'b010000);
    step(SHORT - 1);
    chk("R10 no early reset", oc_flag, 6'b010000);
    step(1);
    chk("R10 resets after interval", oc_flag, 6'b010100);
    oc_raw = '0;
    pulse_clr(6'b111111, '0, '0);
    chk("R4 clear releases", out_dis, 6'b0);

    ol_raw[1] = 1'b1; step(LONG + 6);
    chk("R5 off output ignored", ol_flag, 6'b0);
    out_on[1] = 1'b1; step(LONG - 1);
    chk("R5 long short run", ol_flag, 6'b0);
    step(1);
    chk("R5 ol set", ol_flag, 6'b000010);
    chk("R5 no disable", out_dis, 6'b0);

    glob_raw[0] = 1'b1; step(SHORT);
    chk("R6 warn set", glob_flag, 6'b000001);
    chk("R6 no disable", out_dis, 6'b0);

    glob_raw[1] = 1'b1; step(SHORT);
    chk("R7 tsd set", glob_flag, 6'b000011);
    chk("R7 all off", out_dis, 6'b111111);
    pulse_clr('0, '0, 6'b000010);
    chk("R7 clear ignored hot", glob_flag, 6'b000011);
    glob_raw[1] = 1'b0;
    pulse_clr('0, '0, 6'b000010);
    chk("R7 cleared cool", glob_flag, 6'b000001);
    chk("R7 outputs back", out_dis, 6'b0);

    glob_raw[4] = 1'b1; step(SHORT);
    chk("R8 vsa uv", glob_flag, 6'b010001);
    chk("R8 all off", out_dis, 6'b111111);
    glob_raw[4] = 1'b0; pulse_clr('0, '0, 6'b010000);
    glob_raw[5] = 1'b1; step(SHORT);
    chk("R8 vsb uv", glob_flag, 6'b100001);
    glob_raw[5] = 1'b0; pulse_clr('0, '0, 6'b100000);
    chk("R8 released", out_dis, 6'b0);

    ov_mask = 1'b1; glob_raw[3] = 1'b1; step(SHORT);
    chk("R9 ov latched", glob_flag, 6'b001001);
    chk("R9 masked", out_dis, 6'b0);
    ov_mask = 1'b0; step(1);
    chk("R9 unmasked off", out_dis, 6'b111111);

    standby_i = 1'b1; step(1);
    chk("R1 standby wipe", oc_flag | ol_flag | glob_flag, 6'b0);
    standby_i = 1'b0;
    glob_raw = '0; ol_raw = '0; out_on = '0;
    step(2);

    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int b = 0; b < 6; b++) begin
        if ($urandom_range(15) == 0) oc_raw[b] = ~oc_raw[b];
        if ($urandom_range(15) == 0) ol_raw[b] = ~ol_raw[b];
        if ($urandom_range(31) == 0) out_on[b] = ~out_on[b];
        if ($urandom_range(15) == 0) glob_raw[b] = ~glob_raw[b];
        oc_clr[b]   = ($urandom_range(40) == 0);
        ol_clr[b]   = ($urandom_range(40) == 0);
        glob_clr[b] = ($urandom_range(40) == 0);
      end
      if ($urandom_range(63) == 0) ov_mask = ~ov_mask;
      standby_i = ($urandom_range(999) == 0);
      step(1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule